// File: doc/BRIEF.md
# Low-Power Mode Regulator Controller

This block sequences the supply arrangement of a small microcontroller-style system as it moves between normal operation and four low-power states. Software, or a power manager, places a one-cycle request with a mode code. The controller then switches off the main regulator and either hands the retained domains to the low-power regulator or lets them go dark. It drives a power-enable for each domain: core, SRAM1, SRAM2, standby circuitry and backup. It also drives a retention flag for each of the core, SRAM1 and SRAM2 that says whether their contents survive.

A wakeup input ends a low-power state. Leaving Stop returns straight to Run with state intact. Leaving either Standby variant raises a system reset for a fixed number of cycles. Leaving Shutdown raises a power-on reset alongside the system reset, for its own fixed length. Only the backup domain survives Shutdown.

For Standby, a configuration bit chooses whether SRAM2 stays powered from the low-power regulator. The bit is sampled when the request is taken. A 3-bit status output reports the current state. Every output is registered.

Top module: `lpm_regctl`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, the block is in Run: `mode_status` is 0, and the outputs show the Run pattern of R2.
- R2: In Run (status 0) the main regulator is on and the low-power regulator is off. Core, SRAM1, SRAM2, standby and backup are all powered. All three retention flags are 0, and both reset outputs are 0.
- R3: A `req_valid` pulse with `req_mode`=0 (Stop) in Run gives status 1 on the cycle after the accepting edge. In status 1 the main regulator is off and the low-power regulator is on, all five domains are powered, and all three retention flags are 1.
- R4: A request with `req_mode`=1 (Standby) taken while `keep_sram2`=1 gives status 2 one cycle later. In status 2 the main regulator is off and the low-power regulator is on. Only SRAM2, standby and backup are powered, and only the SRAM2 retention flag is 1.
- R5: A request with `req_mode`=1 taken while `keep_sram2`=0 gives status 3 one cycle later. In status 3 both regulators are off, only standby and backup are powered, and no retention flag is set.
- R6: A request with `req_mode`=2 (Shutdown) gives status 4 one cycle later. In status 4 both regulators are off, only backup is powered, and no retention flag is set.
- R7: Requests are taken only in Run. A request made in any other state leaves the status unchanged. So does `req_mode`=3. A request and a wake in the same Run cycle act as the request alone.
- R8: `keep_sram2` is sampled only at the accepting edge. Changing it during a low-power state has no effect.
- R9: A `wake` in status 1 returns to status 0 on the next cycle, with `sys_rst` low.
- R10: A `wake` in status 2 or 3 gives status 5 for exactly RST_CYCLES cycles, then status 0. Status 5 shows the Run supply pattern with `sys_rst`=1 and `por_rst`=0.
- R11: A `wake` in status 4 gives status 6 for exactly POR_CYCLES cycles, then status 0. Status 6 shows the Run supply pattern with `sys_rst`=1 and `por_rst`=1.
- R12: A `wake` in Run has no effect. The backup domain is powered in every state, and the two regulator enables are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One-cycle low-power request strobe |
| req_mode | input | 2 | 0 Stop, 1 Standby, 2 Shutdown, 3 reserved |
| keep_sram2 | input | 1 | Keep SRAM2 powered through Standby |
| wake | input | 1 | Wakeup event |
| main_reg_en | output | 1 | Main regulator enable |
| lp_reg_en | output | 1 | Low-power regulator enable |
| pwr_core | output | 1 | Core domain powered |
| pwr_sram1 | output | 1 | SRAM1 powered |
| pwr_sram2 | output | 1 | SRAM2 powered |
| pwr_stby | output | 1 | Standby circuitry powered |
| pwr_bkup | output | 1 | Backup domain powered |
| ret_core | output | 1 | Core register contents retained |
| ret_sram1 | output | 1 | SRAM1 contents retained |
| ret_sram2 | output | 1 | SRAM2 contents retained |
| sys_rst | output | 1 | System reset pulse after wake from Standby or Shutdown |
| por_rst | output | 1 | Power-on reset pulse after wake from Shutdown |
| mode_status | output | 3 | Current state: 0 Run, 1 Stop, 2 Standby+SRAM2, 3 Standby, 4 Shutdown, 5 wake reset, 6 wake power-on reset |

## Verification
The bench sweeps every request code against both values of the retention bit. Each time it flips that bit and fires a stray request while the block sits in the low-power state. A design that sampled the bit continuously would drop SRAM2 mid-Standby, and one that took requests outside Run would hop states. The reset windows after wake are checked cycle by cycle, so a counter off by one shows up as a pulse one cycle too short or too long. A Stop wake that passed through the reset path shows up as a spurious `sys_rst`. The bench also checks wake in Run and a same-cycle request and wake, where a wrong priority would leave the block in Run.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_STOP = 3'd1,
    ST_SBR  = 3'd2,
    ST_SBY  = 3'd3,
    ST_SHD  = 3'd4,
    ST_WRST = 3'd5,
    ST_WPOR = 3'd6
  } lpm_state_e;

  localparam logic [1:0] REQ_STOP = 2'd0;
  localparam logic [1:0] REQ_STBY = 2'd1;
  localparam logic [1:0] REQ_SHDN = 2'd2;

  typedef struct packed {
    logic mr;
    logic lp;
    logic core;
    logic sram1;
    logic sram2;
    logic stby;
    logic bkup;
    logic rcore;
    logic rsram1;
    logic rsram2;
    logic srst;
    logic por;
  } dom_ctl_t;

endpackage

// File: rtl/lpm_rst_timer.sv
module lpm_rst_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)            cnt_q <= '0;
    else if (load)      cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter int RST_CYCLES = 4,
  parameter int POR_CYCLES = 8,
  parameter int CW         = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_mode,
  input  logic          keep_sram2,
  input  logic          wake,
  input  logic          tmr_zero,
  output lpm_state_e    state_q,
  output lpm_state_e    state_d,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val
);
  localparam logic [CW-1:0] RST_LOAD = CW'(RST_CYCLES - 1);
  localparam logic [CW-1:0] POR_LOAD = CW'(POR_CYCLES - 1);

  lpm_state_e nxt;

  always_comb begin
    nxt      = state_q;
    tmr_load = 1'b0;
    tmr_val  = RST_LOAD;
    case (state_q)
      ST_RUN: begin
        if (req_valid) begin
          case (req_mode)
            REQ_STOP: nxt = ST_STOP;
            REQ_STBY: nxt = keep_sram2 ? ST_SBR : ST_SBY;
            REQ_SHDN: nxt = ST_SHD;
            default:  nxt = ST_RUN;
          endcase
        end
      end
      ST_STOP: if (wake) nxt = ST_RUN;
      ST_SBR, ST_SBY: begin
        if (wake) begin
          nxt      = ST_WRST;
          tmr_load = 1'b1;
          tmr_val  = RST_LOAD;
        end
      end
      ST_SHD: begin
        if (wake) begin
          nxt      = ST_WPOR;
          tmr_load = 1'b1;
          tmr_val  = POR_LOAD;
        end
      end
      ST_WRST, ST_WPOR: if (tmr_zero) nxt = ST_RUN;
      default: nxt = ST_RUN;
    endcase
  end

  assign state_d = rst ? ST_RUN : nxt;

  always_ff @(posedge clk) begin
    state_q <= state_d;
  end
endmodule

// File: rtl/lpm_domain_map.sv
module lpm_domain_map
  import lpm_pkg::*;
(
  input  lpm_state_e st,
  output dom_ctl_t   dom
);
  always_comb begin
    dom       = '0;
    dom.bkup  = 1'b1;
    case (st)
      ST_STOP: begin
        dom.lp = 1'b1;
        {dom.core, dom.sram1, dom.sram2, dom.stby} = 4'b1111;
        {dom.rcore, dom.rsram1, dom.rsram2}        = 3'b111;
      end
      ST_SBR: begin
        dom.lp     = 1'b1;
        dom.sram2  = 1'b1;
        dom.stby   = 1'b1;
        dom.rsram2 = 1'b1;
      end
      ST_SBY: dom.stby = 1'b1;
      ST_SHD: ;
      default: begin
        dom.mr = 1'b1;
        {dom.core, dom.sram1, dom.sram2, dom.stby} = 4'b1111;
        dom.srst = (st == ST_WRST) || (st == ST_WPOR);
        dom.por  = (st == ST_WPOR);
      end
    endcase
  end
endmodule

// File: rtl/lpm_regctl.sv
module lpm_regctl
  import lpm_pkg::*;
#(
  parameter int RST_CYCLES = 4,
  parameter int POR_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [1:0] req_mode,
  input  logic       keep_sram2,
  input  logic       wake,
  output logic       main_reg_en,
  output logic       lp_reg_en,
  output logic       pwr_core,
  output logic       pwr_sram1,
  output logic       pwr_sram2,
  output logic       pwr_stby,
  output logic       pwr_bkup,
  output logic       ret_core,
  output logic       ret_sram1,
  output logic       ret_sram2,
  output logic       sys_rst,
  output logic       por_rst,
  output logic [2:0] mode_status
);
  localparam int MAXC = (RST_CYCLES > POR_CYCLES) ? RST_CYCLES : POR_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  lpm_state_e    state_q, state_d;
  logic          tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;
  dom_ctl_t      dom_d, dom_q;

  lpm_fsm #(.RST_CYCLES(RST_CYCLES), .POR_CYCLES(POR_CYCLES), .CW(CW)) u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .keep_sram2(keep_sram2), .wake(wake), .tmr_zero(tmr_zero),
    .state_q(state_q), .state_d(state_d), .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  lpm_rst_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  lpm_domain_map u_map (.st(state_d), .dom(dom_d));

  always_ff @(posedge clk) begin
    dom_q <= dom_d;
  end

  assign main_reg_en = dom_q.mr;
  assign lp_reg_en   = dom_q.lp;
  assign pwr_core    = dom_q.core;
  assign pwr_sram1   = dom_q.sram1;
  assign pwr_sram2   = dom_q.sram2;
  assign pwr_stby    = dom_q.stby;
  assign pwr_bkup    = dom_q.bkup;
  assign ret_core    = dom_q.rcore;
  assign ret_sram1   = dom_q.rsram1;
  assign ret_sram2   = dom_q.rsram2;
  assign sys_rst     = dom_q.srst;
  assign por_rst     = dom_q.por;
  assign mode_status = state_q;

  // R12
  reg_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(main_reg_en && lp_reg_en));
  // R12
  bkup_on_chk: assert property (@(posedge clk) disable iff (rst) pwr_bkup);
  // R3
  stop_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_status == 3'd0 && req_valid && req_mode == 2'd0) |=> (mode_status == 3'd1 && lp_reg_en));
  // R9
  stop_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_status == 3'd1 && wake) |=> (mode_status == 3'd0 && !sys_rst));
  // R10
  stby_wake_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode_status == 3'd2 || mode_status == 3'd3) && wake) |=> (sys_rst && !por_rst));
  // R11
  shd_wake_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_status == 3'd4 && wake) |=> (sys_rst && por_rst));
  // R7
  lp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_status >= 3'd1 && mode_status <= 3'd4 && !wake) |=> $stable(mode_status));
endmodule

// File: tb/lpm_regctl_bench.sv
`timescale 1ns/1ps
module lpm_regctl_bench;
  localparam int RSTC = 3;
  localparam int PORC = 5;

  logic clk = 0;
  logic rst, req_valid, keep_sram2, wake;
  logic [1:0] req_mode;
  logic main_reg_en, lp_reg_en, pwr_core, pwr_sram1, pwr_sram2, pwr_stby, pwr_bkup;
  logic ret_core, ret_sram1, ret_sram2, sys_rst, por_rst;
  logic [2:0] mode_status;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lpm_regctl #(.RST_CYCLES(RSTC), .POR_CYCLES(PORC)) u_lpm_regctl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .keep_sram2(keep_sram2), .wake(wake), .main_reg_en(main_reg_en),
    .lp_reg_en(lp_reg_en), .pwr_core(pwr_core), .pwr_sram1(pwr_sram1),
    .pwr_sram2(pwr_sram2), .pwr_stby(pwr_stby), .pwr_bkup(pwr_bkup),
    .ret_core(ret_core), .ret_sram1(ret_sram1), .ret_sram2(ret_sram2),
    .sys_rst(sys_rst), .por_rst(por_rst), .mode_status(mode_status)
  );

  // order: mr lp core sram1 sram2 stby bkup rcore rsram1 rsram2 srst por
  function automatic logic [11:0] exp_vec(int s);
    case (s)
      0: return 12'b1011111_000_00;
      1: return 12'b0111111_111_00;
      2: return 12'b0100111_001_00;
      3: return 12'b0000011_000_00;
      4: return 12'b0000001_000_00;
      5: return 12'b1011111_000_10;
      6: return 12'b1011111_000_11;
      default: return 12'b0;
    endcase
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(int es, string req);
    logic [11:0] got;
    got = {main_reg_en, lp_reg_en, pwr_core, pwr_sram1, pwr_sram2, pwr_stby,
           pwr_bkup, ret_core, ret_sram1, ret_sram2, sys_rst, por_rst};
    tests++;
    if (mode_status !== 3'(es) || got !== exp_vec(es)) begin
      fails++;
      $display("FAIL %s: status=%0d outs=%b expected status=%0d outs=%b",
               req, mode_status, got, es, exp_vec(es));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; req_valid = 0; req_mode = 0; keep_sram2 = 0; wake = 0;
    step(); step();
    chk(0, "R1 in reset");
    req_valid = 1; wake = 1;
    step();
    chk(0, "R1 request held off by reset");
    req_valid = 0; wake = 0; rst = 0;
    step();
    chk(0, "R1 R2 after reset");

    wake = 1; step(); wake = 0;
    chk(0, "R12 wake in Run");
    req_valid = 1; req_mode = 2'd3; step(); req_valid = 0;
    chk(0, "R7 reserved mode");
    step();
    chk(0, "R7 reserved mode settled");

    for (int m = 0; m < 3; m++) begin
      for (int k = 0; k < 2; k++) begin
        int es;
        string rq;
        es = (m == 0) ? 1 : (m == 1) ? (k ? 2 : 3) : 4;
        rq = (m == 0) ? "R3" : (m == 1) ? (k ? "R4" : "R5") : "R6";
        keep_sram2 = k[0]; req_mode = 2'(m); req_valid = 1;
        step(); req_valid = 0;
        chk(es, rq);
        req_valid = 1; req_mode = 2'((m + 1) % 3); keep_sram2 = ~k[0];
        step(); req_valid = 0;
        chk(es, "R7 request outside Run");
        step();
        chk(es, "R8 keep bit changed");
        wake = 1; step(); wake = 0;
        if (m == 0) chk(0, "R9");
        else if (m == 1) begin
          for (int i = 0; i < RSTC; i++) begin chk(5, "R10 reset window"); step(); end
          chk(0, "R10 back to Run");
        end else begin
          for (int i = 0; i < PORC; i++) begin chk(6, "R11 por window"); step(); end
          chk(0, "R11 back to Run");
        end
      end
    end

    req_valid = 1; req_mode = 2'd0; wake = 1;
    step(); req_valid = 0; wake = 0;
    chk(1, "R7 R12 request beats wake");
    wake = 1; step(); wake = 0;
    chk(0, "R9 second wake");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule